// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address from a CPU request into a physical word address by reading one entry of a flat page table that sits in word-addressed memory. The virtual address splits into a 20-bit page number (upper bits) and a 12-bit offset within a 4 KB page. The page table base input names the table of the running process. The entry for the page sits at the base plus the page number, one word per entry.

The walker accepts one request at a time. It reads the entry and checks its valid and permission bits. If the entry's reference or dirty status needs to change, it writes the entry back. It then performs the data read or write at the physical address and returns a one-cycle response. A missing mapping or a forbidden access ends the request with a fault pulse, and no data access is made. Fault handling belongs to software.

Entry word layout: bit 31 valid, bit 30 write permitted, bit 29 read permitted, bit 28 dirty, bit 27 referenced, bits 19:0 physical page number. The memory port completes a read one cycle after the read is issued.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and just after it is released, req_ready is 1, resp_valid is 0 and mem_en is 0.
- R2: The first memory access of each request is a read at ptbr + vaddr[31:12].
- R3: On success, resp_paddr equals {entry[19:0], vaddr[11:0]}, and the data access is made at that address. A read returns the word stored there on resp_rdata, and a write stores req_wdata there.
- R4: An entry with bit 31 clear gives page_fault together with resp_valid, and fault_vpn equals vaddr[31:12]. No further memory access is made and the entry is not changed.
- R5: A write to an entry with bit 30 clear, or a read from an entry with bit 29 clear, gives prot_fault and makes no further memory access.
- R6: A successful access sets bit 27 of the entry, and a write also sets bit 28. The updated entry is written back only when a bit changes, so a request makes 3 memory accesses when the entry changes and 2 when it does not.
- R7: req_ready is low from acceptance until the response cycle, and req_valid is ignored during that time.
- R8: resp_valid lasts exactly one cycle. page_fault and prot_fault are never both high, and each is high only together with resp_valid.
- R9: With base 0x100 and address 0x10020, the entry is read at 0x110. If that entry holds page 0x22, the physical address is 0x22020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 32 | Word address of the current process's page table |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 32 | Translated physical word address |
| resp_rdata | output | 32 | Load data |
| page_fault | output | 1 | Entry not valid |
| prot_fault | output | 1 | Permission denied |
| fault_vpn | output | 20 | Page number of the request |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |

## Verification
The bench targets these corner cases:
- An entry that already has its reference and dirty bits set. A walker that always writes the entry back makes a third access, and the access count catches it.
- A write and a read to the same page in turn. A walker that marks the entry dirty on reads, or fails to mark it on writes, leaves the wrong entry in memory.
- Invalid entries and entries lacking permission. A design that makes the data access anyway corrupts memory or shows an extra access.
- Requests held on req_valid during a walk. A walker that drops its busy state too early would accept them and start a second translation.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int PTE_VALID = 31;
  localparam int PTE_WPERM = 30;
  localparam int PTE_RPERM = 29;
  localparam int PTE_DIRTY = 28;
  localparam int PTE_REF   = 27;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WALK, ST_CHECK, ST_UPD, ST_DATA, ST_DWAIT, ST_RESP
  } walk_state_t;

  // entry after an access: referenced always, dirty on a store
  function automatic logic [31:0] mark_entry(input logic [31:0] pte, input logic is_write);
    logic [31:0] m;
    m = pte;
    m[PTE_REF] = 1'b1;
    if (is_write) m[PTE_DIRTY] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pt_addr_calc.sv
module pt_addr_calc #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 20,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PPN_W-1:0] ppn,
  output logic [VPN_W-1:0] vpn,
  output logic [PA_W-1:0]  entry_addr,
  output logic [PA_W-1:0]  paddr
);
  function automatic logic [PA_W-1:0] entry_of(input logic [PA_W-1:0] b, input logic [VPN_W-1:0] v);
    return b + PA_W'(v);
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] p, input logic [OFF_W-1:0] o);
    return {p, o};
  endfunction

  assign vpn        = vaddr[VA_W-1:OFF_W];
  assign entry_addr = entry_of(base, vpn);
  assign paddr      = join_pa(ppn, vaddr[OFF_W-1:0]);
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int PPN_W = 20
) (
  input  logic [31:0]      pte,
  input  logic             is_write,
  output logic             invalid,
  output logic             prot_bad,
  output logic             need_upd,
  output logic [31:0]      upd_pte,
  output logic [PPN_W-1:0] ppn
);
  assign invalid  = !pte[PTE_VALID];
  assign prot_bad = pte[PTE_VALID] && (is_write ? !pte[PTE_WPERM] : !pte[PTE_RPERM]);
  assign upd_pte  = mark_entry(pte, is_write);
  assign need_upd = !invalid && !prot_bad && (upd_pte != pte);
  assign ppn      = pte[PPN_W-1:0];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 20,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  ptbr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic [31:0]      req_wdata,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [31:0]      resp_rdata,
  output logic             page_fault,
  output logic             prot_fault,
  output logic [VPN_W-1:0] fault_vpn,
  output logic             mem_en,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata
);
  walk_state_t state;
  logic [VA_W-1:0] vaddr_q;
  logic [PA_W-1:0] base_q;
  logic            write_q;
  logic [31:0]     wdata_q, pte_q, rdata_q;
  logic            pf_q, prot_q;

  logic [VPN_W-1:0] vpn;
  logic [PA_W-1:0]  entry_addr, paddr;
  logic             invalid, prot_bad, need_upd;
  logic [31:0]      upd_pte;
  logic [PPN_W-1:0] ppn_new, ppn_q;

  pt_addr_calc #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_addr (
    .base(base_q), .vaddr(vaddr_q), .ppn(ppn_q),
    .vpn(vpn), .entry_addr(entry_addr), .paddr(paddr)
  );

  pt_entry_check #(.PPN_W(PPN_W)) u_chk (
    .pte(mem_rdata), .is_write(write_q),
    .invalid(invalid), .prot_bad(prot_bad), .need_upd(need_upd),
    .upd_pte(upd_pte), .ppn(ppn_new)
  );

  // named events for the checks below
  logic accept_ev, chk_fault_ev, upd_ev;
  assign accept_ev    = req_valid && req_ready;
  assign chk_fault_ev = (state == ST_CHECK) && (invalid || prot_bad);
  assign upd_ev       = (state == ST_UPD);

  assign ppn_q      = pte_q[PPN_W-1:0];
  assign req_ready  = (state == ST_IDLE);
  assign resp_valid = (state == ST_RESP);
  assign page_fault = resp_valid && pf_q;
  assign prot_fault = resp_valid && prot_q;
  assign fault_vpn  = vpn;
  assign resp_paddr = paddr;
  assign resp_rdata = rdata_q;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = entry_addr;
    mem_wdata = pte_q;
    case (state)
      ST_WALK: mem_en = 1'b1;
      ST_UPD:  begin mem_en = 1'b1; mem_we = 1'b1; end
      ST_DATA: begin
        mem_en    = 1'b1;
        mem_we    = write_q;
        mem_addr  = paddr;
        mem_wdata = wdata_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      vaddr_q <= '0;
      base_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      pte_q   <= '0;
      rdata_q <= '0;
      pf_q    <= 1'b0;
      prot_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          base_q  <= ptbr;
          write_q <= req_write;
          wdata_q <= req_wdata;
          pf_q    <= 1'b0;
          prot_q  <= 1'b0;
          state   <= ST_WALK;
        end
        ST_WALK:  state <= ST_CHECK;
        ST_CHECK: begin
          pte_q <= upd_pte;
          if (invalid)       begin pf_q   <= 1'b1; state <= ST_RESP; end
          else if (prot_bad) begin prot_q <= 1'b1; state <= ST_RESP; end
          else if (need_upd) state <= ST_UPD;
          else               state <= ST_DATA;
        end
        ST_UPD:   state <= ST_DATA;
        ST_DATA:  state <= ST_DWAIT;
        ST_DWAIT: begin
          rdata_q <= write_q ? '0 : mem_rdata;
          state   <= ST_RESP;
        end
        ST_RESP:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R2: every accepted request starts with an entry read
  a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (mem_en && !mem_we));
  // R4 / R5: a failed check is followed by no memory access
  a_r4_no_access_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault_ev |=> !mem_en);
  // R6: the write-back always carries the reference bit, and dirty on stores
  a_r6_marked_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ev |-> (mem_we && mem_wdata[PTE_REF] && (!write_q || mem_wdata[PTE_DIRTY])));
  // R7: acceptance drops ready on the next cycle
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !req_ready);
  // R8: one-cycle response, exclusive faults
  a_r8_one_cycle_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  a_r8_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_fault && prot_fault));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 0, rst_n = 0;
  logic [31:0] ptbr = 0, req_vaddr = 0, req_wdata = 0;
  logic        req_valid = 0, req_write = 0;
  logic        req_ready, resp_valid, page_fault, prot_fault, mem_en, mem_we;
  logic [31:0] resp_paddr, resp_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [19:0] fault_vpn;

  int n_cmp = 0, n_bad = 0, acc_cnt = 0;
  logic [31:0] mem    [logic [31:0]];
  logic [31:0] shadow [logic [31:0]];

  always #4 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .ptbr(ptbr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_rdata(resp_rdata),
    .page_fault(page_fault), .prot_fault(prot_fault), .fault_vpn(fault_vpn),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // word memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      acc_cnt = acc_cnt + 1;
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    end
  end

  function automatic logic [31:0] sh_rd(input logic [31:0] a);
    return shadow.exists(a) ? shadow[a] : 32'h0;
  endfunction
  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] exp_entry_addr(input logic [31:0] b, input logic [31:0] va);
    return b + (va >> 12);
  endfunction
  function automatic logic [31:0] exp_pa(input logic [31:0] pte, input logic [31:0] va);
    return ((pte & 32'h000F_FFFF) << 12) | (va & 32'hFFF);
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a] = v;
    shadow[a] = v;
  endtask

  task automatic run_req(input logic [31:0] base, input logic [31:0] va,
                         input logic wr, input logic [31:0] wd);
    logic [31:0] ea, pte, npte, pa, erd;
    bit pf, pv, busy_ok, got;
    int exp_acc;
    ea   = exp_entry_addr(base, va);
    pte  = sh_rd(ea);
    pf   = !pte[31];
    pv   = !pf && !(wr ? pte[30] : pte[29]);
    npte = pte | 32'h0800_0000 | (wr ? 32'h1000_0000 : 32'h0);
    pa   = exp_pa(pte, va);
    erd  = sh_rd(pa);
    exp_acc = (pf || pv) ? 1 : ((npte != pte) ? 3 : 2);

    @(negedge clk);
    check(req_ready == 1'b1, "R7 ready when idle", 32'(req_ready), 1);
    ptbr = base; req_vaddr = va; req_write = wr; req_wdata = wd; req_valid = 1;
    acc_cnt = 0;
    @(negedge clk);
    // R7: keep offering a different request while busy; it must be ignored
    req_vaddr = $urandom; req_write = ~wr; req_wdata = $urandom;
    busy_ok = 1; got = 0;
    for (int i = 0; i < 40; i++) begin
      if (resp_valid) begin got = 1; break; end
      if (req_ready) busy_ok = 0;
      @(negedge clk);
    end
    check(got, "R8 response arrives", 32'(got), 1);
    check(busy_ok && !req_ready, "R7 ready low while busy", 32'(busy_ok), 1);
    check(page_fault == pf, "R4 page_fault", 32'(page_fault), 32'(pf));
    check(prot_fault == pv, "R5 prot_fault", 32'(prot_fault), 32'(pv));
    if (pf) check(fault_vpn == va[31:12], "R4 fault_vpn", 32'(fault_vpn), 32'(va[31:12]));
    if (!pf && !pv) begin
      check(resp_paddr == pa, "R3 physical address", resp_paddr, pa);
      if (!wr) check(resp_rdata == erd, "R3 read data", resp_rdata, erd);
      shadow[ea] = npte;
      if (wr) shadow[pa] = wd;
    end
    req_valid = 0;
    @(negedge clk);
    check(!resp_valid, "R8 response lasts one cycle", 32'(resp_valid), 0);
    check(acc_cnt == exp_acc, "R6 memory access count", 32'(acc_cnt), 32'(exp_acc));
    check(mem_rd(ea) == sh_rd(ea), "R6 entry after access", mem_rd(ea), sh_rd(ea));
    check(mem_rd(pa) == sh_rd(pa), "R3 data word after access", mem_rd(pa), sh_rd(pa));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // two page tables, physical pages placed far above them
    for (int v = 0; v < 16; v++) begin
      put(32'h100 + v, (32'($urandom) & 32'hF800_0000) | 32'h8_0000 | 32'(v));
      put(32'h2000 + v, (32'($urandom) & 32'hF800_0000) | 32'hC_0000 | 32'(v));
    end
    put(32'h110, 32'hE000_0022);          // example entry
    put(32'h22020, 32'h0000_2222);
    put(32'h111, 32'h6000_0033);          // not valid
    put(32'h112, 32'hA000_0044);          // valid, read only
    put(32'h113, 32'hC000_0055);          // valid, write only

    @(negedge clk);
    check(req_ready && !resp_valid && !mem_en, "R1 state in reset", 32'(req_ready), 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !resp_valid && !mem_en, "R1 state after reset", 32'(req_ready), 1);

    // R9 example, then R6 dirty marking and no write-back when unchanged
    run_req(32'h100, 32'h0001_0020, 0, 0);
    check(mem_rd(32'h110) == 32'hE800_0022, "R9 entry referenced", mem_rd(32'h110), 32'hE800_0022);
    run_req(32'h100, 32'h0001_0020, 1, 32'hCAFE_0001);
    check(mem_rd(32'h110) == 32'hF800_0022, "R6 entry dirty", mem_rd(32'h110), 32'hF800_0022);
    run_req(32'h100, 32'h0001_0020, 0, 0);
    check(resp_rdata == 32'hCAFE_0001, "R9 read back", resp_rdata, 32'hCAFE_0001);
    // R2: the entry read goes to base plus page number
    check(exp_entry_addr(32'h100, 32'h0001_0020) == 32'h110, "R2 entry address", 32'h110, 32'h110);
    run_req(32'h100, 32'h0001_1abc, 0, 0);   // R4
    run_req(32'h100, 32'h0001_2004, 1, 32'h5); // R5 write to read-only
    run_req(32'h100, 32'h0001_3008, 0, 0);   // R5 read from write-only
    run_req(32'h100, 32'h0001_3008, 1, 32'h77);

    for (int k = 0; k < 120; k++) begin
      logic [31:0] b, va;
      b  = ($urandom % 2) ? 32'h100 : 32'h2000;
      va = {12'h0, 4'($urandom), 16'($urandom)} & 32'h000F_FFFF;
      va = (va & 32'h0000_0FFF) | ((va & 32'h000F_0000) >> 4);
      run_req(b, va, 1'($urandom), $urandom);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule